// File: doc/BRIEF.md
# Receive Interrupt Coalescing Controller

This block sits beside a network receiver and decides when the host should be interrupted for received frames. Each received frame arrives as a one-cycle strobe with its length. Frames that count as large are gathered into a bundle. One interrupt closes the bundle, either when the bundle holds a programmed number of frames or when an idle countdown, started by the first frame of the bundle, runs out.

Frames that count as small skip the bundle. A frame is small when its length ANDed with a mask is zero. A small frame raises an interrupt on the next cycle and leaves the open bundle alone. This gets short acknowledgement traffic to the host quickly.

The three tuning values arrive on plain input ports: countdown reload, bundle limit and size mask. Typical values are a reload near 0x600, a limit of 6 and a mask of 0xFF80. The block also drives a sticky interrupt flag, which the host clears with an acknowledge input, and the number of frames pending in the open bundle.

Top module: `rx_irq_coalesce`

## Requirements
- R1: A synchronous reset leaves pending_cnt at 0, irq_pulse at 0 and irq_flag at 0 on the cycle after the reset edge.
- R2: A frame with (frame_len & small_mask) != 0 is large. A large frame raises pending_cnt by one on the next cycle. If pending_cnt was 0, the frame loads the countdown with timer_reload; otherwise the countdown is not reloaded.
- R3: While pending_cnt is nonzero, the countdown drops by one per clock. The bundle closes on the clock edge at which the countdown is already 0. For a bundle opened at edge E0 with reload R, irq_pulse is 1 for one cycle after edge E0+R+1, and pending_cnt returns to 0 at the same time.
- R4: When a large frame brings the count to bundle_max or beyond, the bundle closes on that edge: irq_pulse goes to 1 and pending_cnt goes to 0 on the next cycle. Limits of 1 and 0 close a bundle on every large frame.
- R5: A bundle_max of 0xFFFF sets no limit, so only the countdown closes the bundle.
- R6: A frame with (frame_len & small_mask) == 0 is small. A small frame makes irq_pulse 1 on the next cycle. It changes neither pending_cnt nor the time at which the open bundle expires.
- R7: A small_mask of 0xFFFF makes every frame of nonzero length large. A small_mask of 0xF800 makes every frame of 2047 bytes or less small; a 2048-byte frame is then large.
- R8: If a frame arrives on the edge where the countdown expires, the block emits exactly one pulse and the bundle still closes with pending_cnt at 0. This holds for both small and large frames.
- R9: With pending_cnt at 0 and no frame strobe, irq_pulse stays 0 on the next cycle.
- R10: Every pulse sets irq_flag on the same cycle. irq_ack clears irq_flag on the next cycle unless a new pulse arrives on that edge, in which case the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_valid | input | 1 | One-cycle strobe: a frame was received |
| frame_len | input | 16 | Length in bytes of the strobed frame |
| timer_reload | input | 16 | Countdown start value for a new bundle |
| bundle_max | input | 16 | Frames per bundle; 0xFFFF means no limit |
| small_mask | input | 16 | Mask that classifies a frame as small |
| irq_ack | input | 1 | Host acknowledge; clears irq_flag |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_flag | output | 1 | Sticky interrupt flag |
| pending_cnt | output | 16 | Large frames in the open bundle |

## Verification
The assertions assume that frame_len is meaningful only while frame_valid is high. They also assume that the three tuning ports do not change while a bundle is open, because the close-on-limit check compares pending_cnt against the current bundle_max. The directed tasks change tuning values only while the block is held in reset. They strobe at most one frame per cycle and drive every input on the falling edge, so each rising edge sees stable values.

// File: rtl/rx_irq_coalesce.sv
module rx_irq_coalesce #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         frame_valid,
  input  logic [W-1:0] frame_len,
  input  logic [W-1:0] timer_reload,
  input  logic [W-1:0] bundle_max,
  input  logic [W-1:0] small_mask,
  input  logic         irq_ack,
  output logic         irq_pulse,
  output logic         irq_flag,
  output logic [W-1:0] pending_cnt
);
  localparam logic [W-1:0] NO_LIMIT = '1;

  logic [W-1:0] tmr;
  logic [W-1:0] cnt_inc;
  logic [W:0]   cnt_next_wide;
  logic         small_hit, big_hit, active, expire, at_limit, close_b, fire;

  assign small_hit     = frame_valid && ((frame_len & small_mask) == '0);
  assign big_hit       = frame_valid && !small_hit;
  assign active        = pending_cnt != '0;
  assign expire        = active && (tmr == '0);
  assign cnt_next_wide = {1'b0, pending_cnt} + 1'b1;
  assign cnt_inc       = (pending_cnt == NO_LIMIT) ? pending_cnt : cnt_next_wide[W-1:0];
  assign at_limit      = big_hit && (bundle_max != NO_LIMIT) &&
                         (cnt_next_wide >= {1'b0, bundle_max});
  assign close_b       = expire || at_limit;
  assign fire          = close_b || small_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_cnt <= '0;
      tmr         <= '0;
      irq_pulse   <= 1'b0;
      irq_flag    <= 1'b0;
    end else begin
      irq_pulse <= fire;
      irq_flag  <= fire || (irq_flag && !irq_ack);
      if (close_b) begin
        pending_cnt <= '0;
        tmr         <= '0;
      end else if (big_hit) begin
        pending_cnt <= cnt_inc;
        tmr         <= active ? tmr - 1'b1 : timer_reload;
      end else if (active) begin
        tmr <= tmr - 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_irq_coalesce_chk.sv
module rx_irq_coalesce_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         frame_valid,
  input logic [W-1:0] frame_len,
  input logic [W-1:0] bundle_max,
  input logic [W-1:0] small_mask,
  input logic         irq_ack,
  input logic         irq_pulse,
  input logic         irq_flag,
  input logic [W-1:0] pending_cnt
);
  logic is_small;
  assign is_small = (frame_len & small_mask) == '0;

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (pending_cnt == '0 && !irq_pulse && !irq_flag));

  a_r4_limit_close: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && !is_small && bundle_max != '1 &&
     ({1'b0, pending_cnt} + 1'b1) >= {1'b0, bundle_max})
    |=> (irq_pulse && pending_cnt == '0));

  a_r6_small_bypass: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && is_small && pending_cnt == '0)
    |=> (irq_pulse && pending_cnt == '0));

  a_r9_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    (!frame_valid && pending_cnt == '0) |=> !irq_pulse);

  a_r10_flag_ack: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> (irq_flag == irq_pulse));

  a_r10_flag_set: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> irq_flag);
endmodule

bind rx_irq_coalesce rx_irq_coalesce_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .frame_valid(frame_valid), .frame_len(frame_len),
  .bundle_max(bundle_max), .small_mask(small_mask), .irq_ack(irq_ack),
  .irq_pulse(irq_pulse), .irq_flag(irq_flag), .pending_cnt(pending_cnt)
);

// File: tb/sim_rx_irq_coalesce.sv
`timescale 1ns/1ps
module sim_rx_irq_coalesce;
  logic clk = 0, rst = 1, frame_valid = 0, irq_ack = 0;
  logic [15:0] frame_len = 0, timer_reload = 16'h600, bundle_max = 16'd6, small_mask = 16'hFF80;
  logic irq_pulse, irq_flag;
  logic [15:0] pending_cnt;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  rx_irq_coalesce u0 (
    .clk(clk), .rst(rst), .frame_valid(frame_valid), .frame_len(frame_len),
    .timer_reload(timer_reload), .bundle_max(bundle_max), .small_mask(small_mask),
    .irq_ack(irq_ack), .irq_pulse(irq_pulse), .irq_flag(irq_flag),
    .pending_cnt(pending_cnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic restart(input logic [15:0] rl, input logic [15:0] mx, input logic [15:0] mk);
    @(negedge clk);
    rst = 1; timer_reload = rl; bundle_max = mx; small_mask = mk;
    @(negedge clk);
    rst = 0;
  endtask

  task automatic frame(input logic [15:0] len);
    frame_valid = 1; frame_len = len;
    @(negedge clk);
    frame_valid = 0; frame_len = 0;
  endtask

  task automatic idle_expect(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, irq_pulse, 0);
    end
  endtask

  task automatic t_reset();
    restart(16'd10, 16'd6, 16'hFF80);
    chk("R1 cnt", pending_cnt, 0);
    chk("R1 pulse", irq_pulse, 0);
    chk("R1 flag", irq_flag, 0);
    idle_expect(20, "R9 idle");
  endtask

  task automatic t_timer();
    restart(16'd5, 16'd6, 16'hFF80);
    frame(16'd200);
    chk("R2 count", pending_cnt, 1);
    chk("R2 no pulse", irq_pulse, 0);
    idle_expect(5, "R3 before expiry");
    @(negedge clk);
    chk("R3 expiry pulse", irq_pulse, 1);
    chk("R3 cnt cleared", pending_cnt, 0);
    @(negedge clk);
    chk("R3 single pulse", irq_pulse, 0);
    frame(16'd300);
    idle_expect(2, "R2 no reload");
    frame(16'd300);
    chk("R2 second frame", pending_cnt, 2);
    idle_expect(2, "R2 no reload");
    @(negedge clk);
    chk("R2 expiry not reloaded", irq_pulse, 1);
  endtask

  task automatic t_limit();
    restart(16'd1000, 16'd3, 16'hFF80);
    frame(16'd128); frame(16'd500);
    chk("R4 below limit", pending_cnt, 2);
    chk("R4 no pulse", irq_pulse, 0);
    frame(16'd1500);
    chk("R4 limit pulse", irq_pulse, 1);
    chk("R4 limit clears", pending_cnt, 0);
    restart(16'd1000, 16'd1, 16'hFF80);
    frame(16'd400);
    chk("R4 max1 pulse", irq_pulse, 1);
    chk("R4 max1 cnt", pending_cnt, 0);
    restart(16'd1000, 16'd0, 16'hFF80);
    frame(16'd400);
    chk("R4 max0 pulse", irq_pulse, 1);
    chk("R4 max0 cnt", pending_cnt, 0);
  endtask

  task automatic t_unlimited();
    restart(16'd20, 16'hFFFF, 16'hFF80);
    for (int i = 0; i < 10; i++) begin
      frame(16'd256);
      chk("R5 no limit", irq_pulse, 0);
    end
    chk("R5 count", pending_cnt, 10);
    idle_expect(11, "R5 waiting");
    @(negedge clk);
    chk("R5 timer close", irq_pulse, 1);
    chk("R5 cnt", pending_cnt, 0);
  endtask

  task automatic t_small();
    restart(16'd10, 16'd6, 16'hFF80);
    frame(16'd200);
    frame(16'd64);
    chk("R6 small pulse", irq_pulse, 1);
    chk("R6 cnt kept", pending_cnt, 1);
    idle_expect(9, "R6 timer kept");
    @(negedge clk);
    chk("R6 expiry unchanged", irq_pulse, 1);
    frame(16'd127);
    chk("R6 small alone", irq_pulse, 1);
    chk("R6 cnt zero", pending_cnt, 0);
  endtask

  task automatic t_masks();
    restart(16'd1000, 16'd6, 16'hFFFF);
    frame(16'd1);
    chk("R7 ffff big", pending_cnt, 1);
    chk("R7 ffff no pulse", irq_pulse, 0);
    restart(16'd1000, 16'd6, 16'hF800);
    frame(16'd2047);
    chk("R7 f800 small", irq_pulse, 1);
    chk("R7 f800 cnt", pending_cnt, 0);
    frame(16'd2048);
    chk("R7 f800 big", pending_cnt, 1);
    chk("R7 f800 big no pulse", irq_pulse, 0);
  endtask

  task automatic t_coincide();
    restart(16'd2, 16'd6, 16'hFF80);
    frame(16'd600);
    idle_expect(2, "R8 wait");
    frame(16'd40);
    chk("R8 small+expiry pulse", irq_pulse, 1);
    chk("R8 closed", pending_cnt, 0);
    @(negedge clk);
    chk("R8 one pulse", irq_pulse, 0);
    frame(16'd600);
    idle_expect(2, "R8 wait");
    frame(16'd700);
    chk("R8 big+expiry pulse", irq_pulse, 1);
    chk("R8 big closed", pending_cnt, 0);
    @(negedge clk);
    chk("R8 big one pulse", irq_pulse, 0);
  endtask

  task automatic t_flag();
    restart(16'd1000, 16'd6, 16'hFF80);
    frame(16'd10);
    chk("R10 flag set", irq_flag, 1);
    idle_expect(3, "R10 quiet");
    chk("R10 flag sticky", irq_flag, 1);
    irq_ack = 1;
    @(negedge clk);
    irq_ack = 0;
    chk("R10 ack clears", irq_flag, 0);
    irq_ack = 1;
    frame(16'd10);
    irq_ack = 0;
    chk("R10 pulse beats ack", irq_flag, 1);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_timer(); t_limit(); t_unlimited();
        t_small(); t_masks(); t_coincide(); t_flag();
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule